// File: doc/BRIEF.md
# Asynchronous Schedule Reclamation and Doorbell Tracker

This block follows the traversal of a host controller's circular list of asynchronous queue heads. A traversal engine reports what it does as single-cycle event pulses: a queue head was fetched (with that descriptor's list-head marker), a transaction from the list was executed, or the schedule was started. From these the block keeps a one-bit reclamation flag. When a list-head-marked descriptor turns up while the flag is already clear, no work was done during a whole lap of the list, and the block pulses a stop request so the engine can go idle.

The block also completes the software unlink handshake. Software rings a doorbell after it removes descriptors from the list. The block then waits until the engine has passed the list-head descriptor a set number of times (two by default). That guarantees the engine holds no cached pointer to the removed entries. The block then raises an advance status bit, drops the doorbell and, if enabled, asserts an interrupt. Software clears the status by writing one to it, and may then ring the doorbell again.

Top module: `async_sched_tracker`

## Requirements
- R1: After reset, reclaimFlag, stopTraversal, doorbellBit, advanceStatus and advanceIrq are all 0.
- R2: A fetch with qhHeadBit=1 clears reclaimFlag at the next clock edge, unless a set event (R3) occurs in the same cycle.
- R3: txnExec=1 or schedStart=1 sets reclaimFlag at the next clock edge. A set wins over a clear arriving in the same cycle.
- R4: A fetch with qhHeadBit=1 in a cycle where reclaimFlag is 0 (the value before that cycle's update) makes stopTraversal 1 for exactly the following cycle.
- R5: stopTraversal stays 0 after a head-marked fetch seen while reclaimFlag is 1, and after any fetch with qhHeadBit=0.
- R6: A doorbell write while advanceStatus is 0 sets doorbellBit at the next edge and restarts the head-pass count at zero, even if doorbellBit was already 1.
- R7: While doorbellBit is 1, each head-marked fetch counts one pass. advanceStatus rises at the edge of the HEAD_PASSES-th such fetch (default 2), and not earlier. Fetches with qhHeadBit=0 do not count.
- R8: doorbellBit returns to 0 on the same edge at which advanceStatus rises. The two are never 1 together.
- R9: A doorbell write while advanceStatus is 1 is ignored: doorbellBit stays 0.
- R10: statusAck=1 clears advanceStatus at the next edge (write-one-to-clear). With advanceStatus at 0 it has no effect.
- R11: advanceIrq is 1 exactly when advanceStatus and irqEnable are both 1.
- R12: A fetch with qhHeadBit=0 and no set event leaves reclaimFlag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qhFetchValid | input | 1 | Engine fetched a queue head this cycle |
| qhHeadBit | input | 1 | List-head marker of the fetched queue head |
| txnExec | input | 1 | Engine executed a transaction from the asynchronous list |
| schedStart | input | 1 | Asynchronous schedule started |
| doorbellWrite | input | 1 | Software writes 1 to the doorbell command bit |
| statusAck | input | 1 | Software writes 1 to the advance status bit (clears it) |
| irqEnable | input | 1 | Interrupt enable for the advance status |
| reclaimFlag | output | 1 | Reclamation flag |
| stopTraversal | output | 1 | One-cycle request to stop traversal: schedule empty |
| doorbellBit | output | 1 | Doorbell command bit as software reads it |
| advanceStatus | output | 1 | Advance status bit |
| advanceIrq | output | 1 | Interrupt output |

## Verification
Every registered output changes on the first clock edge after the cycle that carries its event. The driver applies one cycle of stimulus at a falling edge and queues the outputs its model predicts for after the next rising edge. The monitor samples a short delay after that rising edge and compares against the queue head. advanceIrq is combinational from advanceStatus and irqEnable, so it is checked in the same sample against the enable held for that cycle. Same-cycle collisions such as head-plus-transaction, doorbell rewrite during counting and doorbell-during-status have their own steps, so the latency holds for every case.

// File: rtl/async_sched_pkg.sv
package async_sched_pkg;

  // Strobes from the control decode to the state registers.
  typedef struct packed {
    logic setReclaim;
    logic clrReclaim;
    logic raiseStop;
    logic armDoorbell;
    logic countHead;
    logic completeAdv;
    logic clearAdv;
  } ctlStrobes_t;

endpackage

// File: rtl/async_sched_ctrl.sv
module async_sched_ctrl
  import async_sched_pkg::*;
#(
  parameter int HEAD_PASSES = 2,
  localparam int CNT_W = $clog2(HEAD_PASSES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qhFetchValid,
  input  logic             qhHeadBit,
  input  logic             txnExec,
  input  logic             schedStart,
  input  logic             doorbellWrite,
  input  logic             statusAck,
  input  logic             reclaimQ,
  input  logic             doorbellQ,
  input  logic             statusQ,
  input  logic [CNT_W-1:0] passCount,
  output ctlStrobes_t      strobes
);

  localparam logic [CNT_W-1:0] PASS_MAX  = CNT_W'(HEAD_PASSES);
  localparam logic [CNT_W-1:0] PASS_LAST = CNT_W'(HEAD_PASSES - 1);

  logic headSeen;
  logic armNow;
  logic countNow;

  always_comb begin
    headSeen = qhFetchValid & qhHeadBit;
    armNow   = doorbellWrite & ~statusQ;
    countNow = headSeen & doorbellQ & ~armNow & (passCount < PASS_MAX);

    strobes             = '0;
    strobes.setReclaim  = txnExec | schedStart;
    strobes.clrReclaim  = headSeen;
    strobes.raiseStop   = headSeen & ~reclaimQ;
    strobes.armDoorbell = armNow;
    strobes.countHead   = countNow;
    strobes.completeAdv = countNow & (passCount == PASS_LAST);
    strobes.clearAdv    = statusAck & statusQ;
  end

  // R7: a completion is only decoded while a doorbell is pending
  p_complete_needs_db_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.completeAdv |-> (doorbellQ && !statusQ));

  // R9: doorbell never armed while status still set
  p_no_arm_on_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusQ |-> !strobes.armDoorbell);

endmodule

// File: rtl/async_sched_dp.sv
module async_sched_dp
  import async_sched_pkg::*;
#(
  parameter int HEAD_PASSES = 2,
  localparam int CNT_W = $clog2(HEAD_PASSES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             qhFetchValid,
  input  logic             qhHeadBit,
  input  logic             txnExec,
  input  logic             schedStart,
  input  logic             doorbellWrite,
  input  logic             statusAck,
  output logic             reclaimQ,
  output logic             stopQ,
  output logic             doorbellQ,
  output logic             statusQ,
  output logic [CNT_W-1:0] passCount
);

  localparam logic [CNT_W-1:0] PASS_MAX = CNT_W'(HEAD_PASSES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reclaimQ  <= 1'b0;
      stopQ     <= 1'b0;
      doorbellQ <= 1'b0;
      statusQ   <= 1'b0;
      passCount <= '0;
    end else begin
      // set wins over clear
      if (strobes.setReclaim)      reclaimQ <= 1'b1;
      else if (strobes.clrReclaim) reclaimQ <= 1'b0;

      stopQ <= strobes.raiseStop;

      if (strobes.armDoorbell) begin
        doorbellQ <= 1'b1;
        passCount <= '0;
      end else if (strobes.countHead) begin
        passCount <= passCount + 1'b1;
        if (strobes.completeAdv) doorbellQ <= 1'b0;
      end

      if (strobes.completeAdv)   statusQ <= 1'b1;
      else if (strobes.clearAdv) statusQ <= 1'b0;
    end
  end

  // R2
  p_head_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (qhFetchValid && qhHeadBit && !txnExec && !schedStart) |=> !reclaimQ);

  // R3
  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txnExec || schedStart) |=> reclaimQ);

  // R4
  p_empty_stops_r4: assert property (@(posedge clk) disable iff (!rstN)
    (qhFetchValid && qhHeadBit && !reclaimQ) |=> stopQ);

  // R5
  p_busy_no_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reclaimQ || !qhFetchValid || !qhHeadBit) |=> !stopQ);

  // R6
  p_arm_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doorbellWrite && !statusQ) |=> (doorbellQ && passCount == '0));

  // R7
  p_status_after_db_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ) |-> $past(doorbellQ));

  p_count_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    passCount <= PASS_MAX);

  // R8
  p_db_status_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(doorbellQ && statusQ));

  // R9
  p_db_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doorbellWrite && statusQ) |=> !doorbellQ);

  // R10
  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statusAck && statusQ) |=> !statusQ);

endmodule

// File: rtl/async_sched_tracker.sv
module async_sched_tracker
  import async_sched_pkg::*;
#(
  parameter int HEAD_PASSES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic qhFetchValid,
  input  logic qhHeadBit,
  input  logic txnExec,
  input  logic schedStart,
  input  logic doorbellWrite,
  input  logic statusAck,
  input  logic irqEnable,
  output logic reclaimFlag,
  output logic stopTraversal,
  output logic doorbellBit,
  output logic advanceStatus,
  output logic advanceIrq
);

  localparam int CNT_W = $clog2(HEAD_PASSES + 1);

  ctlStrobes_t      strobes;
  logic             reclaimQ;
  logic             stopQ;
  logic             doorbellQ;
  logic             statusQ;
  logic [CNT_W-1:0] passCount;

  async_sched_ctrl #(.HEAD_PASSES(HEAD_PASSES)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .qhFetchValid  (qhFetchValid),
    .qhHeadBit     (qhHeadBit),
    .txnExec       (txnExec),
    .schedStart    (schedStart),
    .doorbellWrite (doorbellWrite),
    .statusAck     (statusAck),
    .reclaimQ      (reclaimQ),
    .doorbellQ     (doorbellQ),
    .statusQ       (statusQ),
    .passCount     (passCount),
    .strobes       (strobes)
  );

  async_sched_dp #(.HEAD_PASSES(HEAD_PASSES)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .qhFetchValid  (qhFetchValid),
    .qhHeadBit     (qhHeadBit),
    .txnExec       (txnExec),
    .schedStart    (schedStart),
    .doorbellWrite (doorbellWrite),
    .statusAck     (statusAck),
    .reclaimQ      (reclaimQ),
    .stopQ         (stopQ),
    .doorbellQ     (doorbellQ),
    .statusQ       (statusQ),
    .passCount     (passCount)
  );

  assign reclaimFlag   = reclaimQ;
  assign stopTraversal = stopQ;
  assign doorbellBit   = doorbellQ;
  assign advanceStatus = statusQ;
  assign advanceIrq    = statusQ & irqEnable;

  initial begin
    p_params_r7: assert (HEAD_PASSES >= 1);
  end

  // R11
  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rstN)
    advanceIrq |-> (advanceStatus && irqEnable));

endmodule

// File: tb/async_sched_tracker_tb.sv
module async_sched_tracker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PASSES     = 2;

  typedef struct {
    logic  rec;
    logic  stop;
    logic  db;
    logic  sts;
    logic  irq;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic qhFetchValid = 1'b0, qhHeadBit = 1'b0, txnExec = 1'b0, schedStart = 1'b0;
  logic doorbellWrite = 1'b0, statusAck = 1'b0, irqEnable = 1'b0;
  logic reclaimFlag, stopTraversal, doorbellBit, advanceStatus, advanceIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  expItem_t expQ[$];

  // bench model state
  logic mRec = 0, mStop = 0, mDb = 0, mSts = 0;
  int   mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_sched_tracker #(.HEAD_PASSES(PASSES)) dut_i (
    .clk(clk), .rstN(rstN),
    .qhFetchValid(qhFetchValid), .qhHeadBit(qhHeadBit),
    .txnExec(txnExec), .schedStart(schedStart),
    .doorbellWrite(doorbellWrite), .statusAck(statusAck),
    .irqEnable(irqEnable),
    .reclaimFlag(reclaimFlag), .stopTraversal(stopTraversal),
    .doorbellBit(doorbellBit), .advanceStatus(advanceStatus),
    .advanceIrq(advanceIrq)
  );

  task automatic cmp(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued
  task automatic step(logic f, logic h, logic t, logic s,
                      logic d, logic a, logic en, string tag);
    logic head, setR, arm, nRec, nStop, nDb, nSts;
    int nCnt;
    expItem_t it;
    @(negedge clk);
    qhFetchValid = f; qhHeadBit = h; txnExec = t; schedStart = s;
    doorbellWrite = d; statusAck = a; irqEnable = en;
    head  = f & h;
    setR  = t | s;
    nRec  = setR ? 1'b1 : (head ? 1'b0 : mRec);
    nStop = head & ~mRec;
    arm   = d & ~mSts;
    nDb = mDb; nSts = mSts; nCnt = mCnt;
    if (arm) begin
      nDb = 1'b1; nCnt = 0;
    end else if (head && mDb && mCnt < PASSES) begin
      nCnt = mCnt + 1;
      if (nCnt == PASSES) begin nDb = 1'b0; nSts = 1'b1; end
    end
    if (a && mSts) nSts = 1'b0;
    mRec = nRec; mStop = nStop; mDb = nDb; mSts = nSts; mCnt = nCnt;
    it.rec = nRec; it.stop = nStop; it.db = nDb; it.sts = nSts;
    it.irq = nSts & en; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: sample after each rising edge
  always @(posedge clk) begin
    #2;
    if (rstN && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      cmp(e.tag, "reclaimFlag",   reclaimFlag,   e.rec);
      cmp(e.tag, "stopTraversal", stopTraversal, e.stop);
      cmp(e.tag, "doorbellBit",   doorbellBit,   e.db);
      cmp(e.tag, "advanceStatus", advanceStatus, e.sts);
      cmp(e.tag, "advanceIrq",    advanceIrq,    e.irq);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cmp("R1", "reclaimFlag",   reclaimFlag,   1'b0);
    cmp("R1", "stopTraversal", stopTraversal, 1'b0);
    cmp("R1", "doorbellBit",   doorbellBit,   1'b0);
    cmp("R1", "advanceStatus", advanceStatus, 1'b0);
    cmp("R1", "advanceIrq",    advanceIrq,    1'b0);
    rstN = 1'b1;

    step(0,0,0,1, 0,0,0, "R3");   // schedule start sets flag
    step(1,0,0,0, 0,0,0, "R12");  // non-head fetch: no change
    step(1,1,0,0, 0,0,0, "R2");   // head clears, flag was 1
    step(0,0,0,0, 0,0,0, "R5");   // no stop followed
    step(1,1,0,0, 0,0,0, "R4");   // head with flag 0 -> stop
    step(0,0,0,0, 0,0,0, "R4");   // stop lasts one cycle
    step(1,1,1,0, 0,0,0, "R3");   // head + txn: stop and set
    step(1,1,0,0, 0,0,0, "R5");   // flag was 1: no stop
    step(0,0,1,0, 0,0,0, "R3");   // txn alone sets

    step(0,0,0,0, 1,0,1, "R6");   // ring doorbell
    step(1,1,0,0, 0,0,1, "R7");   // first pass, not done
    step(1,0,0,0, 0,0,1, "R7");   // non-head fetch does not count
    step(1,1,0,0, 0,0,1, "R8");   // second pass: status, doorbell clears
    step(0,0,0,0, 0,0,1, "R11");  // irq with enable
    step(0,0,0,0, 0,0,0, "R11");  // irq masked
    step(0,0,0,0, 1,0,1, "R9");   // doorbell ignored during status
    step(1,1,0,0, 0,0,1, "R9");   // heads do nothing, no doorbell
    step(0,0,0,0, 0,1,1, "R10");  // ack clears
    step(0,0,0,0, 0,1,1, "R10");  // ack while clear: no effect

    step(0,0,0,0, 1,0,1, "R6");   // ring again
    step(1,1,0,0, 0,0,1, "R7");   // one pass
    step(0,0,0,0, 1,0,1, "R6");   // rewrite restarts count
    step(1,1,0,0, 0,0,1, "R7");   // one pass since restart
    step(0,0,0,0, 0,0,1, "R7");   // still pending
    step(1,1,0,0, 0,0,1, "R7");   // second pass: status
    step(0,0,0,0, 1,1,1, "R9");   // doorbell + ack together: doorbell ignored
    step(0,0,0,0, 0,0,0, "R10");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule